// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block drives a 24-pin liquid-crystal panel by time multiplexing. Software fills a bank of 21 four-bit display registers with segment on/off data and writes a control register that picks one of three duties (1/4, 1/3 or 1/2) and turns the display on or off. The duty fixes how many of the low pins act as commons (4, 3 or 2). Every remaining pin is a segment, so the panel can carry 80, 63 or 44 segments.

While the display is on, a prescaler paces a common scan. For every pin and every scan step the block outputs a 2-bit drive-level code (0, lower intermediate, upper intermediate, full) for an external bias ladder. It also outputs a frame-polarity bit that flips after every full frame so that the panel sees no net DC. 1/4 and 1/3 duty use third bias. 1/2 duty uses half bias. A fixed, computed map assigns each display bit to one segment pin and common.

The scan is a three-state machine. ST_BLANK means the display is off. ST_POS and ST_NEG are the two frame polarities. The transitions are named as follows. "enable" goes from ST_BLANK to ST_POS on a control write with the display on. "frame_flip" goes from ST_POS to ST_NEG, or back, when the last common finishes. "restart" goes from ST_POS or ST_NEG to ST_POS on any control write with the display on. "blank" goes from ST_POS or ST_NEG to ST_BLANK on a control write with the display off.

Top module: `lcd_mux_driver`

## Requirements
- R1: After reset, the display is off, the duty is 1/4, every display register holds 0, every pin level code is 0 and frame_pol is 0.
- R2: A control write (ctrl_we) loads the duty from ctrl_duty (0 = 1/4, 1 = 1/3, 2 = 1/2, 3 = 1/4) and the on bit from ctrl_disp_on. If the display is on, every such write restarts the scan in the next cycle at common 0 with frame_pol 0 and a cleared prescaler.
- R3: A display write (wr_en) stores wr_data into register wr_addr for addresses 0 to 20. Writes to addresses 21 to 31 change nothing.
- R4: With N commons, pins 0 to N-1 are commons and pins N to 23 are segments. The data bit for segment pin p at common c is bit k = (p-N)*N + c, read from register k/4 at bit position k%4.
- R5: While scanning, each common stays selected for exactly TICK_DIV clock cycles. After common N-1 the scan wraps to common 0 and frame_pol toggles.
- R6: Level codes are 0, 1, 2 and 3, on pin_lvl[2p+1:2p]. Under third bias with frame_pol 0, the selected common is 3, an unselected common is 1, an on segment is 0 and an off segment is 2. With frame_pol 1 these become 0, 2, 3 and 1.
- R7: Under half bias (1/2 duty) with frame_pol 0, the selected common is 3, an unselected common is 1, an on segment is 0 and an off segment is 1. With frame_pol 1 the selected common is 0 and an on segment is 3. Code 2 is never used.
- R8: While the display is off, every pin is at level 0 and frame_pol is 0, whatever the register contents are.
- R9: While scanning, exactly one common pin is at the selected extreme level: 3 when frame_pol is 0, 0 when it is 1. No segment pin is ever at that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Display register write strobe |
| wr_addr | input | 5 | Display register index |
| wr_data | input | 4 | Display register write data |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_duty | input | 2 | Duty code: 0 = 1/4, 1 = 1/3, 2 = 1/2, 3 = 1/4 |
| ctrl_disp_on | input | 1 | Display enable |
| pin_lvl | output | 48 | Two-bit level code per pin; pin p at bits 2p+1:2p |
| frame_pol | output | 1 | Current frame polarity |

## Verification
The scan runs under each duty with several data patterns: a mixed pattern, all ones, all zeros, and a single walking bit. The mixed pattern checks the bit-to-segment map. The all-ones and all-zeros patterns separate the on and off levels of each bias. The walking bit exposes any index error in the map. Control writes also land in the middle of a frame, which separates a true restart from continued counting, and duty code 3 shows the fallback to 1/4. Writes to the unused addresses 21 to 31 during a scan, together with a display-off phase that holds data, show that neither of them reaches the pins.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

    localparam int MAX_COMS = 4;
    localparam int COM_W    = $clog2(MAX_COMS);
    localparam int NCOM_W   = $clog2(MAX_COMS + 1);

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_POS   = 2'd1,
        ST_NEG   = 2'd2
    } scan_state_t;

    typedef enum logic [1:0] {
        LV_ZERO = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_FULL = 2'd3
    } drive_lvl_t;

    function automatic logic [NCOM_W-1:0] duty_to_ncom(input logic [1:0] code);
        unique case (code)
            2'd1:    return NCOM_W'(3);
            2'd2:    return NCOM_W'(2);
            default: return NCOM_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !clear && (cnt_q == LAST);

endmodule

// File: rtl/lcd_disp_regs.sv
module lcd_disp_regs #(
    parameter int NUM_REGS = 21,
    parameter int REG_W    = 4,
    parameter int ADDR_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] bank
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[i*REG_W +: REG_W] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                bank[i*REG_W +: REG_W] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm
    import lcd_mux_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [1:0]        ctrl_duty,
    input  logic              ctrl_disp_on,
    output logic [COM_W-1:0]  com_idx,
    output logic [NCOM_W-1:0] ncom,
    output logic              scanning,
    output logic              neg_frame
);
    scan_state_t       state_q, state_d;
    logic [COM_W-1:0]  com_q, com_d;
    logic [NCOM_W-1:0] ncom_q;
    logic              tick, last_com, pre_clear;

    assign last_com  = ({1'b0, com_q} == (ncom_q - NCOM_W'(1)));
    assign pre_clear = ctrl_we || (state_q == ST_BLANK);

    lcd_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pre_clear),
        .tick  (tick)
    );

    always_comb begin
        state_d = state_q;
        com_d   = com_q;
        unique case (state_q)
            ST_BLANK: begin
                com_d = '0;
                if (ctrl_we && ctrl_disp_on) state_d = ST_POS;
            end
            ST_POS, ST_NEG: begin
                if (ctrl_we) begin
                    com_d   = '0;
                    state_d = ctrl_disp_on ? ST_POS : ST_BLANK;
                end else if (tick) begin
                    if (last_com) begin
                        com_d   = '0;
                        state_d = (state_q == ST_POS) ? ST_NEG : ST_POS;
                    end else begin
                        com_d = com_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_BLANK;
                com_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLANK;
            com_q   <= '0;
            ncom_q  <= NCOM_W'(MAX_COMS);
        end else begin
            state_q <= state_d;
            com_q   <= com_d;
            if (ctrl_we) ncom_q <= duty_to_ncom(ctrl_duty);
        end
    end

    always_comb begin
        com_idx   = com_q;
        ncom      = ncom_q;
        scanning  = 1'b0;
        neg_frame = 1'b0;
        unique case (state_q)
            ST_POS:  scanning = 1'b1;
            ST_NEG:  begin scanning = 1'b1; neg_frame = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/lcd_pin_encoder.sv
module lcd_pin_encoder
    import lcd_mux_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int BITS     = 84
) (
    input  logic [BITS-1:0]       bank,
    input  logic [COM_W-1:0]      com_idx,
    input  logic [NCOM_W-1:0]     ncom,
    input  logic                  scanning,
    input  logic                  neg_frame,
    output logic [2*NUM_PINS-1:0] pin_lvl
);
    localparam int IDX_W = $clog2(BITS);

    logic half_bias;
    assign half_bias = (ncom == NCOM_W'(2));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        drive_lvl_t lvl;
        logic       is_com, seg_on;
        int         k;

        always_comb begin
            is_com = (p < int'(ncom));
            k      = (p - int'(ncom)) * int'(ncom) + int'(com_idx);
            seg_on = 1'b0;
            if (!is_com && k >= 0 && k < BITS) seg_on = bank[k[IDX_W-1:0]];

            if (!scanning) begin
                lvl = LV_ZERO;
            end else if (is_com) begin
                if (p == int'(com_idx))  lvl = neg_frame ? LV_ZERO : LV_FULL;
                else if (half_bias)      lvl = LV_LOW;
                else                     lvl = neg_frame ? LV_HIGH : LV_LOW;
            end else begin
                if (seg_on)              lvl = neg_frame ? LV_FULL : LV_ZERO;
                else if (half_bias)      lvl = LV_LOW;
                else                     lvl = neg_frame ? LV_LOW : LV_HIGH;
            end
        end

        assign pin_lvl[2*p +: 2] = lvl;
    end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
    import lcd_mux_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int NUM_REGS = 21,
    parameter int REG_W    = 4,
    parameter int TICK_DIV = 4,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    input  logic                  ctrl_we,
    input  logic [1:0]            ctrl_duty,
    input  logic                  ctrl_disp_on,
    output logic [2*NUM_PINS-1:0] pin_lvl,
    output logic                  frame_pol
);
    localparam int BITS = NUM_REGS * REG_W;

    logic [BITS-1:0]   bank;
    logic [COM_W-1:0]  com_idx;
    logic [NCOM_W-1:0] ncom;
    logic              scanning, neg_frame;

    lcd_disp_regs #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank    (bank)
    );

    lcd_scan_fsm #(.TICK_DIV(TICK_DIV)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_we),
        .ctrl_duty    (ctrl_duty),
        .ctrl_disp_on (ctrl_disp_on),
        .com_idx      (com_idx),
        .ncom         (ncom),
        .scanning     (scanning),
        .neg_frame    (neg_frame)
    );

    lcd_pin_encoder #(
        .NUM_PINS (NUM_PINS),
        .BITS     (BITS)
    ) u_enc (
        .bank      (bank),
        .com_idx   (com_idx),
        .ncom      (ncom),
        .scanning  (scanning),
        .neg_frame (neg_frame),
        .pin_lvl   (pin_lvl)
    );

    assign frame_pol = neg_frame;

endmodule

// File: rtl/lcd_mux_driver_chk.sv
module lcd_mux_driver_chk
    import lcd_mux_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ctrl_we,
    input logic                  ctrl_disp_on,
    input logic [2*NUM_PINS-1:0] pin_lvl,
    input logic                  frame_pol,
    input logic [NCOM_W-1:0]     ncom,
    input logic                  scanning
);
    int   sel_cnt;
    logic seg_bad, uses_high;

    always_comb begin
        sel_cnt   = 0;
        seg_bad   = 1'b0;
        uses_high = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_lvl[2*p +: 2] == (frame_pol ? 2'd0 : 2'd3)) begin
                if (p < int'(ncom)) sel_cnt++;
                else                seg_bad = 1'b1;
            end
            if (pin_lvl[2*p +: 2] == 2'd2) uses_high = 1'b1;
        end
    end

    // R8
    blank_all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && !ctrl_disp_on |=> (pin_lvl == '0) && !frame_pol);

    // R2
    restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we && ctrl_disp_on |=> !frame_pol && (pin_lvl[1:0] == 2'd3));

    // R9
    one_common_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> sel_cnt == 1);

    // R9
    seg_not_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> !seg_bad);

    // R7
    half_bias_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scanning && (ncom == NCOM_W'(2)) |-> !uses_high);

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scanning |-> (pin_lvl == '0) && !frame_pol);

endmodule

bind lcd_mux_driver lcd_mux_driver_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .ctrl_disp_on (ctrl_disp_on),
    .pin_lvl      (pin_lvl),
    .frame_pol    (frame_pol),
    .ncom         (ncom),
    .scanning     (scanning)
);

// File: tb/test_lcd_mux_driver.sv
module test_lcd_mux_driver;
    localparam int PINS = 24;
    localparam int REGS = 21;
    localparam int DIV  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [3:0]        wr_data = '0;
    logic              ctrl_we = 1'b0;
    logic [1:0]        ctrl_duty = '0;
    logic              ctrl_disp_on = 1'b0;
    logic [2*PINS-1:0] pin_lvl;
    logic              frame_pol;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference state
    int dmem[REGS];
    int m_on = 0, m_ncom = 4, m_pol = 0, m_com = 0, m_cnt = 0;

    always #5 clk = ~clk;

    lcd_mux_driver #(.TICK_DIV(DIV)) i_lcd_mux_driver (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ctrl_we      (ctrl_we),
        .ctrl_duty    (ctrl_duty),
        .ctrl_disp_on (ctrl_disp_on),
        .pin_lvl      (pin_lvl),
        .frame_pol    (frame_pol)
    );

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            foreach (dmem[i]) dmem[i] = 0;
            m_on = 0; m_ncom = 4; m_pol = 0; m_com = 0; m_cnt = 0;
        end else begin
            // R3: only addresses below 21 land
            if (wr_en && int'(wr_addr) < REGS) dmem[int'(wr_addr)] = int'(wr_data);
            if (ctrl_we) begin
                // R2
                m_ncom = (ctrl_duty == 2'd1) ? 3 : (ctrl_duty == 2'd2) ? 2 : 4;
                m_on   = int'(ctrl_disp_on);
                m_com  = 0; m_cnt = 0; m_pol = 0;
            end else if (m_on != 0) begin
                // R5
                if (m_cnt == DIV - 1) begin
                    m_cnt = 0;
                    if (m_com == m_ncom - 1) begin m_com = 0; m_pol ^= 1; end
                    else m_com++;
                end else m_cnt++;
            end
        end
    end

    function automatic int exp_lvl(int p);
        int k, b;
        bit half;
        if (m_on == 0) return 0;                               // R8
        half = (m_ncom == 2);
        if (p < m_ncom) begin                                  // R9
            if (p == m_com) return m_pol ? 0 : 3;
            return half ? 1 : (m_pol ? 2 : 1);
        end
        k = (p - m_ncom) * m_ncom + m_com;                     // R4
        b = (dmem[k / 4] >> (k % 4)) & 1;
        if (b != 0) return m_pol ? 3 : 0;
        if (half) return 1;                                    // R7
        return m_pol ? 1 : 2;                                  // R6
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int bad = 0;
            checks++;
            if (int'(frame_pol) != m_pol) begin
                bad = 1;
                $display("FAIL R5 frame_pol actual=%0d expected=%0d t=%0t",
                         frame_pol, m_pol, $time);
            end
            for (int p = 0; p < PINS; p++) begin
                int a = int'(pin_lvl[2*p +: 2]);
                int e = exp_lvl(p);
                if (a != e) begin
                    string tag;
                    bad = 1;
                    if (m_on == 0)        tag = "R8";
                    else if (p < m_ncom)  tag = "R9";
                    else if (m_ncom == 2) tag = "R7";
                    else                  tag = "R4/R6";
                    $display("FAIL %s pin%0d actual=%0d expected=%0d t=%0t",
                             tag, p, a, e, $time);
                end
            end
            if (bad != 0) fails++;
        end
    end

    task automatic wr_reg(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 4'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ctrl(int duty, bit on);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_duty = 2'(duty); ctrl_disp_on = on;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic fill(int mode);
        for (int i = 0; i < REGS; i++) begin
            int d;
            case (mode)
                0: d = (i * 5 + 3) & 15;
                1: d = 15;
                2: d = 0;
                default: d = (i == 7) ? 4 : 0;
            endcase
            wr_reg(i, d);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1", int'(pin_lvl != '0), 0);
        check("R1", int'(frame_pol), 0);

        fill(0);                       // R8: data present, display still off
        check("R8", int'(pin_lvl != '0), 0);

        wr_ctrl(0, 1'b1);              // 1/4 duty
        // R2: one cycle after the write, common 0 selected, positive frame
        check("R2", int'(pin_lvl[1:0]), 3);
        check("R2", int'(frame_pol), 0);
        idle(70);
        for (int a = 21; a < 32; a++) wr_reg(a, 15);   // R3 ignored writes
        idle(40);
        wr_ctrl(1, 1'b1);              // 1/3 duty
        idle(60);
        idle(5);
        wr_ctrl(1, 1'b1);              // R2 restart mid-frame
        idle(30);
        wr_ctrl(2, 1'b1);              // 1/2 duty
        idle(50);
        fill(1);
        idle(40);
        wr_ctrl(3, 1'b1);              // code 3 -> 1/4
        idle(40);
        fill(2);
        idle(40);
        fill(3);                       // walking bit
        for (int d = 0; d < 3; d++) begin
            wr_ctrl(d, 1'b1);
            idle(50);
        end
        wr_ctrl(0, 1'b0);              // R8 display off
        check("R8", int'(pin_lvl != '0), 0);
        idle(20);
        fill(1);
        check("R8", int'(frame_pol), 0);
        wr_ctrl(2, 1'b1);
        idle(30);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles >= 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule